// File: doc/BRIEF.md
# Memory-Mapped Compare Timer Frame

This block is one frame of a memory-mapped system timer. It holds a free-running 64-bit count, a physical compare timer and, when enabled at build time, a second "virtual" compare timer that works against the count minus a fixed 64-bit offset. Each timer is programmed through a signed 32-bit down-count register and a three-bit control register, and each drives its own level interrupt line.

Software arms a timer by writing the down-count first and then the control word with the enable bit set and the mask bit clear. The condition flag stays visible in the control word even while the interrupt line is masked, so a handler can mask first and still see why it was called. The 64-bit count is read as two 32-bit words; a consistent value takes a high read, a low read and a second high read, retried when the two highs differ.

A constant capability word reports virtual-timer presence in the 4-bit slot of this frame's number, for the control frame that sits beside the timer frames.

Top module: `gtimer_frame`

## Requirements
- R1: The physical count loads RESET_COUNT in reset and rises by exactly one each clock. Offset 0x00 returns its low word and 0x04 its high word.
- R2: Offset 0x10 returns the FREQ_HZ parameter (zero meaning the rate is unknown).
- R3: A write to a timer's down-count register (physical 0x28, virtual 0x38) sets its compare value to the current count plus the sign-extended write data. A read returns the compare value minus the current count, truncated to 32 bits.
- R4: Control bit 2, the condition flag, reads 1 exactly when enable (bit 0) is 1 and the timer's count is at or above its compare value. Writes to bit 2 have no effect.
- R5: A timer's interrupt output is high one clock after its flag is 1 with the mask (bit 1) at 0. Setting the mask drops the line while the flag still reads 1.
- R6: Clearing enable drops the flag at once and the interrupt line on the following clock.
- R7: Offsets 0x08/0x0C return the low/high words of the virtual count, which is the physical count minus VIRT_OFFSET. The virtual timer (0x38 down-count, 0x3C control) compares against that count and drives irq_virt.
- R8: With VIRT_PRESENT at 0, offsets 0x38 and 0x3C read zero, writes to them change nothing, and irq_virt stays low.
- R9: Any offset not listed above reads zero.
- R10: cap_word has bit 4*FRAME_ID+1 equal to VIRT_PRESENT and all other bits zero.
- R11: rdata carries the addressed value in the cycle after rd_en is sampled high, and zero after a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset within the frame |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq_phys | output | 1 | Physical timer level interrupt |
| irq_virt | output | 1 | Virtual timer level interrupt |
| cap_word | output | DATA_W | Capability word for this frame |

## Verification
A wrong compare value or control bit inside a timer shows up on its interrupt line one clock after the count crosses the compare point, and in the flag and down-count read-backs on the very next read. A count that slips or jumps shows up at once in the down-count read-back and in back-to-back count reads. The bench therefore compares both interrupt lines and the read data against a reference model on every clock, so any divergence is reported in the cycle it reaches a port.

// File: rtl/gtimer_pkg.sv
package gtimer_pkg;
  // Byte offsets within the timer frame
  localparam logic [11:0] OFF_PCNT_LO = 12'h000;
  localparam logic [11:0] OFF_PCNT_HI = 12'h004;
  localparam logic [11:0] OFF_VCNT_LO = 12'h008;
  localparam logic [11:0] OFF_VCNT_HI = 12'h00C;
  localparam logic [11:0] OFF_FREQ    = 12'h010;
  localparam logic [11:0] OFF_P_DOWN  = 12'h028;
  localparam logic [11:0] OFF_P_CTRL  = 12'h02C;
  localparam logic [11:0] OFF_V_DOWN  = 12'h038;
  localparam logic [11:0] OFF_V_CTRL  = 12'h03C;

  // Control word bit positions
  localparam int CTL_EN   = 0;
  localparam int CTL_MASK = 1;
  localparam int CTL_FLAG = 2;
  localparam int CTL_W    = 3;

  // Capability slot width per frame
  localparam int CAP_SLOT_W   = 4;
  localparam int CAP_VIRT_BIT = 1;
endpackage

// File: rtl/gtimer_counter.sv
module gtimer_counter #(
  parameter int          CW   = 64,
  parameter logic [63:0] INIT = 64'd0
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= CW'(INIT);
    else     count <= count + CW'(1);
  end
endmodule

// File: rtl/gtimer_cmp.sv
module gtimer_cmp
  import gtimer_pkg::*;
#(
  parameter int CW = 64,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic          down_we,
  input  logic          ctl_we,
  input  logic [DW-1:0] wdata,
  output logic          en,
  output logic          mask,
  output logic          flag,
  output logic [DW-1:0] down_rd,
  output logic          irq
);
  localparam int EXT = CW - DW;

  logic [CW-1:0] cval;
  logic [CW-1:0] delta;

  assign delta   = {{EXT{wdata[DW-1]}}, wdata};
  assign flag    = en && (cnt >= cval);
  assign down_rd = DW'(cval - cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cval <= '0;
      en   <= 1'b0;
      mask <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= flag && !mask;
      if (down_we) cval <= cnt + delta;
      if (ctl_we) begin
        en   <= wdata[CTL_EN];
        mask <= wdata[CTL_MASK];
      end
    end
  end
endmodule

// File: rtl/gtimer_regif.sv
module gtimer_regif
  import gtimer_pkg::*;
#(
  parameter int          AW      = 12,
  parameter int          DW      = 32,
  parameter int          CW      = 64,
  parameter bit          VIRT    = 1'b1,
  parameter logic [31:0] FREQ_HZ = 32'd0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [CW-1:0]    pcnt,
  input  logic [CW-1:0]    vcnt,
  input  logic [DW-1:0]    p_down,
  input  logic [CTL_W-1:0] p_ctl,
  input  logic [DW-1:0]    v_down,
  input  logic [CTL_W-1:0] v_ctl,
  output logic             p_down_we,
  output logic             p_ctl_we,
  output logic             v_down_we,
  output logic             v_ctl_we,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] rd_next;

  assign p_down_we = wr_en && (addr == AW'(OFF_P_DOWN));
  assign p_ctl_we  = wr_en && (addr == AW'(OFF_P_CTRL));
  assign v_down_we = VIRT && wr_en && (addr == AW'(OFF_V_DOWN));
  assign v_ctl_we  = VIRT && wr_en && (addr == AW'(OFF_V_CTRL));

  always_comb begin
    rd_next = '0;
    if (rd_en) begin
      unique case (addr)
        AW'(OFF_PCNT_LO): rd_next = pcnt[DW-1:0];
        AW'(OFF_PCNT_HI): rd_next = pcnt[CW-1:DW];
        AW'(OFF_VCNT_LO): rd_next = vcnt[DW-1:0];
        AW'(OFF_VCNT_HI): rd_next = vcnt[CW-1:DW];
        AW'(OFF_FREQ):    rd_next = DW'(FREQ_HZ);
        AW'(OFF_P_DOWN):  rd_next = p_down;
        AW'(OFF_P_CTRL):  rd_next = DW'(p_ctl);
        AW'(OFF_V_DOWN):  rd_next = VIRT ? v_down : '0;
        AW'(OFF_V_CTRL):  rd_next = VIRT ? DW'(v_ctl) : '0;
        default:          rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/gtimer_frame.sv
module gtimer_frame
  import gtimer_pkg::*;
#(
  parameter int          ADDR_W       = 12,
  parameter int          DATA_W       = 32,
  parameter int          CNT_W        = 2 * DATA_W,
  parameter logic [31:0] FREQ_HZ      = 32'd50_000_000,
  parameter bit          VIRT_PRESENT = 1'b1,
  parameter logic [63:0] VIRT_OFFSET  = 64'd0,
  parameter logic [63:0] RESET_COUNT  = 64'd0,
  parameter int          FRAME_ID     = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_phys,
  output logic              irq_virt,
  output logic [DATA_W-1:0] cap_word
);
  localparam int CAP_POS = FRAME_ID * CAP_SLOT_W + CAP_VIRT_BIT;

  logic [CNT_W-1:0]  pcount;
  logic [CNT_W-1:0]  vcount;
  logic              p_down_we, p_ctl_we, v_down_we, v_ctl_we;
  logic              p_en, p_mask, p_flag;
  logic              v_en, v_mask, v_flag;
  logic [DATA_W-1:0] p_down, v_down;
  logic [CTL_W-1:0]  p_ctl, v_ctl;

  gtimer_counter #(.CW(CNT_W), .INIT(RESET_COUNT)) u_cnt (
    .clk(clk), .rst(rst), .count(pcount)
  );

  assign vcount = pcount - CNT_W'(VIRT_OFFSET);

  gtimer_cmp #(.CW(CNT_W), .DW(DATA_W)) u_pcmp (
    .clk(clk), .rst(rst), .cnt(pcount),
    .down_we(p_down_we), .ctl_we(p_ctl_we), .wdata(wdata),
    .en(p_en), .mask(p_mask), .flag(p_flag),
    .down_rd(p_down), .irq(irq_phys)
  );

  generate
    if (VIRT_PRESENT) begin : g_virt
      gtimer_cmp #(.CW(CNT_W), .DW(DATA_W)) u_vcmp (
        .clk(clk), .rst(rst), .cnt(vcount),
        .down_we(v_down_we), .ctl_we(v_ctl_we), .wdata(wdata),
        .en(v_en), .mask(v_mask), .flag(v_flag),
        .down_rd(v_down), .irq(irq_virt)
      );
    end else begin : g_novirt
      assign v_en     = 1'b0;
      assign v_mask   = 1'b0;
      assign v_flag   = 1'b0;
      assign v_down   = '0;
      assign irq_virt = 1'b0;
    end
  endgenerate

  always_comb begin
    p_ctl           = '0;
    p_ctl[CTL_EN]   = p_en;
    p_ctl[CTL_MASK] = p_mask;
    p_ctl[CTL_FLAG] = p_flag;
    v_ctl           = '0;
    v_ctl[CTL_EN]   = v_en;
    v_ctl[CTL_MASK] = v_mask;
    v_ctl[CTL_FLAG] = v_flag;
  end

  always_comb begin
    cap_word          = '0;
    cap_word[CAP_POS] = VIRT_PRESENT;
  end

  gtimer_regif #(
    .AW(ADDR_W), .DW(DATA_W), .CW(CNT_W),
    .VIRT(VIRT_PRESENT), .FREQ_HZ(FREQ_HZ)
  ) u_regif (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .pcnt(pcount), .vcnt(vcount),
    .p_down(p_down), .p_ctl(p_ctl), .v_down(v_down), .v_ctl(v_ctl),
    .p_down_we(p_down_we), .p_ctl_we(p_ctl_we),
    .v_down_we(v_down_we), .v_ctl_we(v_ctl_we),
    .rdata(rdata)
  );
endmodule

// File: rtl/gtimer_frame_chk.sv
module gtimer_frame_chk #(
  parameter int DW   = 32,
  parameter int CW   = 64,
  parameter bit VIRT = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_en,
  input logic [DW-1:0] rdata,
  input logic          irq_phys,
  input logic          irq_virt,
  input logic [CW-1:0] count,
  input logic          p_en,
  input logic          p_mask,
  input logic          p_flag
);
  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> count == $past(count) + CW'(1));

  // R5
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_phys) |-> ($past(p_flag) && !$past(p_mask)));

  // R5
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    p_mask |=> !irq_phys);

  // R6
  irq_disable_chk: assert property (@(posedge clk) disable iff (rst)
    !p_en |=> !irq_phys);

  // R8
  irq_absent_chk: assert property (@(posedge clk) disable iff (rst)
    !VIRT |-> !irq_virt);

  // R11
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> rdata == '0);
endmodule

bind gtimer_frame gtimer_frame_chk #(
  .DW(DATA_W), .CW(CNT_W), .VIRT(VIRT_PRESENT)
) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rdata(rdata),
  .irq_phys(irq_phys), .irq_virt(irq_virt), .count(pcount),
  .p_en(p_en), .p_mask(p_mask), .p_flag(p_flag)
);

// File: tb/test_gtimer_frame.sv
`timescale 1ns/1ps
module test_gtimer_frame;
  localparam logic [63:0] RC   = 64'h0000_0000_FFFF_FF00;
  localparam logic [63:0] VOFF = 64'h10;
  localparam logic [31:0] FRQ  = 32'd50_000_000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b, cap_a, cap_b;
  logic        irqp_a, irqv_a, irqp_b, irqv_b;

  int checks = 0;
  int fails  = 0;
  bit started = 1'b0;

  always #2 clk = ~clk;

  gtimer_frame #(.FREQ_HZ(FRQ), .VIRT_PRESENT(1'b1), .VIRT_OFFSET(VOFF),
                 .RESET_COUNT(RC), .FRAME_ID(2)) i_gtimer_frame (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_a), .irq_phys(irqp_a), .irq_virt(irqv_a),
    .cap_word(cap_a));

  gtimer_frame #(.VIRT_PRESENT(1'b0), .FRAME_ID(3)) i_gtimer_frame_novirt (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_b), .irq_phys(irqp_b), .irq_virt(irqv_b),
    .cap_word(cap_b));

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Reference model of frame A
  logic [63:0] m_cnt, m_pcv, m_vcv;
  logic        m_pen, m_pmask, m_ven, m_vmask, m_pirq, m_virq;
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_read(input logic [11:0] a);
    logic [63:0] vc;
    vc = m_cnt - VOFF;
    case (a)
      12'h000: return m_cnt[31:0];
      12'h004: return m_cnt[63:32];
      12'h008: return vc[31:0];
      12'h00C: return vc[63:32];
      12'h010: return FRQ;
      12'h028: return 32'(m_pcv - m_cnt);
      12'h02C: return {29'd0, m_pen && (m_cnt >= m_pcv), m_pmask, m_pen};
      12'h038: return 32'(m_vcv - vc);
      12'h03C: return {29'd0, m_ven && (vc >= m_vcv), m_vmask, m_ven};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= RC; m_pcv <= '0; m_vcv <= '0;
      m_pen <= 0; m_pmask <= 0; m_ven <= 0; m_vmask <= 0;
      m_pirq <= 0; m_virq <= 0; m_rdata <= '0;
    end else begin
      m_pirq  <= m_pen && (m_cnt >= m_pcv) && !m_pmask;
      m_virq  <= m_ven && ((m_cnt - VOFF) >= m_vcv) && !m_vmask;
      m_rdata <= rd_en ? m_read(addr) : 32'd0;
      if (wr_en) begin
        case (addr)
          12'h028: m_pcv <= m_cnt + {{32{wdata[31]}}, wdata};
          12'h02C: begin m_pen <= wdata[0]; m_pmask <= wdata[1]; end
          12'h038: m_vcv <= (m_cnt - VOFF) + {{32{wdata[31]}}, wdata};
          12'h03C: begin m_ven <= wdata[0]; m_vmask <= wdata[1]; end
          default: ;
        endcase
      end
      m_cnt <= m_cnt + 64'd1;
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (started && !rst) begin
      chk(irqp_a == m_pirq, "R5 irq_phys vs model", 64'(irqp_a), 64'(m_pirq));
      chk(irqv_a == m_virq, "R7 irq_virt vs model", 64'(irqv_a), 64'(m_virq));
      chk(rdata_a == m_rdata, "R11 rdata vs model", 64'(rdata_a), 64'(m_rdata));
      chk(irqv_b == 1'b0, "R8 irq_virt absent", 64'(irqv_b), 64'd0);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] da,
                    output logic [31:0] db);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    da = rdata_a; db = rdata_b;
    rd_en = 1'b0; addr = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] a, b, a2, b2;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    started = 1'b1;
    // Reset state
    chk(rdata_a == 0, "R11 reset rdata", 64'(rdata_a), 0);
    chk(!irqp_a && !irqv_a, "R5 reset irq", 64'({irqp_a, irqv_a}), 0);
    // R10 capability words
    chk(cap_a == 32'h200, "R10 cap present frame2", 64'(cap_a), 64'h200);
    chk(cap_b == 32'h0, "R10 cap absent frame3", 64'(cap_b), 0);
    // R1 count: high word before wrap, consecutive low reads
    rd(12'h004, a, b);
    chk(a == 32'd0, "R1 high word before wrap", 64'(a), 0);
    rd(12'h000, a, b);
    rd(12'h000, a2, b2);
    chk(a2 == a + 32'd1, "R1 count step", 64'(a2), 64'(a + 32'd1));
    // R2 frequency
    rd(12'h010, a, b);
    chk(a == FRQ, "R2 frequency", 64'(a), 64'(FRQ));
    // R9 unmapped
    rd(12'h020, a, b);
    chk(a == 0, "R9 unmapped 0x20", 64'(a), 0);
    rd(12'hFFC, a, b);
    chk(a == 0, "R9 unmapped 0xFFC", 64'(a), 0);
    // R3 down-count write/read
    wr(12'h028, 32'd50);
    rd(12'h028, a, b);
    chk(a == 32'd49, "R3 down-count read", 64'(a), 49);
    // R4 arm, flag clear before expiry
    wr(12'h02C, 32'h1);
    rd(12'h02C, a, b);
    chk(a == 32'h1, "R4 flag before expiry", 64'(a), 1);
    idle(60);
    rd(12'h02C, a, b);
    chk(a == 32'h5, "R4 flag after expiry", 64'(a), 5);
    chk(irqp_a == 1'b1, "R5 irq asserted", 64'(irqp_a), 1);
    // R5 mask keeps flag visible
    wr(12'h02C, 32'h3);
    idle(2);
    chk(irqp_a == 1'b0, "R5 masked irq low", 64'(irqp_a), 0);
    rd(12'h02C, a, b);
    chk(a == 32'h7, "R5 flag readable while masked", 64'(a), 7);
    // R4/R6 flag write ignored, disable clears
    wr(12'h02C, 32'h4);
    rd(12'h02C, a, b);
    chk(a == 32'h0, "R4 flag write ignored R6 disabled", 64'(a), 0);
    // R3 negative down-count fires at once
    wr(12'h028, 32'hFFFF_FFFB);
    wr(12'h02C, 32'h1);
    rd(12'h02C, a, b);
    chk(a == 32'h5, "R3 negative down-count flag", 64'(a), 5);
    chk(irqp_a == 1'b1, "R3 negative down-count irq", 64'(irqp_a), 1);
    // R6 disable
    wr(12'h02C, 32'h0);
    idle(1);
    chk(irqp_a == 1'b0, "R6 irq low after disable", 64'(irqp_a), 0);
    // R7 virtual count and timer
    rd(12'h000, a, b);
    rd(12'h008, a2, b2);
    chk(a2 == a + 32'd1 - 32'h10, "R7 virtual count", 64'(a2), 64'(a + 32'd1 - 32'h10));
    wr(12'h038, 32'd20);
    wr(12'h03C, 32'h1);
    chk(irqv_a == 1'b0, "R7 virt irq before expiry", 64'(irqv_a), 0);
    idle(30);
    chk(irqv_a == 1'b1, "R7 virt irq after expiry", 64'(irqv_a), 1);
    rd(12'h03C, a, b);
    chk(a == 32'h5, "R7 virt flag", 64'(a), 5);
    wr(12'h03C, 32'h0);
    // R8 absent virtual timer ignores writes
    wr(12'h038, 32'd0);
    wr(12'h03C, 32'h1);
    rd(12'h03C, a, b);
    chk(b == 32'h0, "R8 absent ctrl reads zero", 64'(b), 0);
    rd(12'h038, a, b);
    chk(b == 32'h0, "R8 absent down-count reads zero", 64'(b), 0);
    idle(2);
    chk(irqv_b == 1'b0, "R8 absent irq low", 64'(irqv_b), 0);
    wr(12'h03C, 32'h0);
    // R1 high word after wrap
    idle(300);
    rd(12'h004, a, b);
    chk(a == 32'd1, "R1 high word after wrap", 64'(a), 1);
    idle(2);
    summary();
    $finish;
  end
endmodule